// File: doc/BRIEF.md
# Signed Halfword Indexed Load Unit

This block executes a load of a signed 16-bit value for a processor pipeline. It receives an already-decoded operation: addressing-mode flags, register indices, an unsigned immediate offset and the current value of the base register. It also receives a flag saying whether the operation's condition passed. It forms an offset address by adding the immediate to the base or subtracting it from the base. It then chooses either that address or the untouched base as the access address, and issues one 2-byte read on a request/grant/response memory port.

When the read data returns, the unit widens the halfword to 32 bits by copying its sign bit. It presents that value on a destination write port, together with a one-cycle completion pulse. When the operation asks for base update, it presents the offset address on a second write port in the same cycle. If both writes target the same register, the data write wins and the base write is dropped.

The number of cycles an operation takes depends only on the memory handshake, never on the value that was loaded.

Top module: `shload_unit`

## Requirements
- R1: The offset address equals base plus offset when `add_i` is 1 and base minus offset when `add_i` is 0, modulo 2^32.
- R2: `mem_addr_o` equals the offset address when `index_i` is 1 and the unmodified base when `index_i` is 0 (post-indexed).
- R3: `mem_req_o` rises in the cycle after an accepted start and stays high, with `mem_addr_o` stable, until a cycle in which `mem_gnt_i` is 1.
- R4: A start with `cond_ok_i` at 0 produces no request, no completion pulse, no register write, and leaves `busy_o` at 0.
- R5: `rd_data_o` is the halfword sampled on `mem_rdata_i` with `mem_rvalid_i` high, with bit 15 copied into bits 31:16.
- R6: `done_o` is high for exactly one cycle, the cycle after `mem_rvalid_i` is seen while waiting, and `rd_we_o` is high exactly when `done_o` is, with `rd_idx_o` equal to the captured destination index.
- R7: When `wback_i` was 1 and the indices differ, `rb_we_o` is high with `done_o` and `rb_data_o` equals the offset address; when `wback_i` was 0, `rb_we_o` stays 0.
- R8: When `wback_i` was 1 and the base index equals the destination index, `rb_we_o` stays 0 and only the data write occurs.
- R9: A start presented while `busy_o` is 1 is ignored; the operation in progress keeps its address and result.
- R10: The cycles from `mem_rvalid_i` to `done_o` do not depend on the loaded data value.
- R11: After reset, `mem_req_o`, `done_o`, `rd_we_o`, `rb_we_o` and `busy_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Operation start pulse |
| cond_ok_i | input | 1 | Condition passed for this operation |
| index_i | input | 1 | 1: access at offset address; 0: access at base |
| add_i | input | 1 | 1: add offset; 0: subtract offset |
| wback_i | input | 1 | Write the offset address back to the base register |
| base_idx_i | input | IDX_W | Base register index |
| dst_idx_i | input | IDX_W | Destination register index |
| offs_i | input | OFS_W | Unsigned immediate offset |
| base_val_i | input | XLEN | Base register value |
| busy_o | output | 1 | Operation in progress |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | XLEN | Read byte address |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | HW | Read halfword |
| done_o | output | 1 | One-cycle completion pulse |
| rd_we_o | output | 1 | Destination write strobe |
| rd_idx_o | output | IDX_W | Destination register index |
| rd_data_o | output | XLEN | Sign-extended load result |
| rb_we_o | output | 1 | Base write strobe |
| rb_idx_o | output | IDX_W | Base register index |
| rb_data_o | output | XLEN | Updated base value |

## Verification
Operations run with every combination of the index and add flags. Offsets are chosen near zero and near the top of the address range, so that add-versus-subtract errors and missing wraparound give different addresses. Loaded halfwords with bit 15 set and clear, including 0x8000 and 0x7FFF, show whether the sign extension copies the right bit. Equal and unequal base and destination indices with base update set and clear separate the writeback cases. Grant and response delays of zero and several cycles, a start with the condition failed and a start raised mid-operation test the handshake and the acceptance rules.

// File: rtl/shload_pkg.sv
package shload_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } shl_state_e;
endpackage

// File: rtl/shload_agu.sv
module shload_agu #(
  parameter int XLEN  = 32,
  parameter int OFS_W = 12
) (
  input  logic [XLEN-1:0]  base_i,
  input  logic [OFS_W-1:0] offs_i,
  input  logic             add_i,
  input  logic             index_i,
  output logic [XLEN-1:0]  offs_addr_o,
  output logic [XLEN-1:0]  acc_addr_o
);
  localparam int PadW = XLEN - OFS_W;

  logic [XLEN-1:0] offs_ext;

  generate
    if (PadW > 0) begin : g_pad
      assign offs_ext = {{PadW{1'b0}}, offs_i};
    end else begin : g_nopad
      assign offs_ext = offs_i[XLEN-1:0];
    end
  endgenerate

  always_comb begin
    if (add_i) offs_addr_o = base_i + offs_ext;
    else       offs_addr_o = base_i - offs_ext;
    acc_addr_o = index_i ? offs_addr_o : base_i;
  end
endmodule

// File: rtl/shload_fsm.sv
module shload_fsm
  import shload_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       cond_ok_i,
  input  logic       gnt_i,
  input  logic       rvalid_i,
  output logic       accept_o,
  output logic       take_o,
  output logic       req_o,
  output logic       busy_o
);
  shl_state_e state_q, state_d;

  assign accept_o = (state_q == ST_IDLE) && start_i && cond_ok_i;
  assign take_o   = (state_q == ST_WAIT) && rvalid_i;
  assign req_o    = (state_q == ST_REQ);
  assign busy_o   = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_o) state_d = ST_REQ;
      ST_REQ:  if (gnt_i)    state_d = ST_WAIT;
      ST_WAIT: if (rvalid_i) state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/shload_result.sv
module shload_result #(
  parameter int XLEN  = 32,
  parameter int HW    = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [HW-1:0]    rdata_i,
  input  logic             wback_i,
  input  logic [IDX_W-1:0] base_idx_i,
  input  logic [IDX_W-1:0] dst_idx_i,
  output logic             done_o,
  output logic             rd_we_o,
  output logic [XLEN-1:0]  rd_data_o,
  output logic             rb_we_o
);
  localparam int ExtW = XLEN - HW;

  logic          done_q;
  logic [HW-1:0] half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      half_q <= '0;
    end else begin
      done_q <= take_i;
      if (take_i) half_q <= rdata_i;
    end
  end

  assign rd_data_o = {{ExtW{half_q[HW-1]}}, half_q};
  assign done_o    = done_q;
  assign rd_we_o   = done_q;
  // data write wins on index collision
  assign rb_we_o   = done_q && wback_i && (base_idx_i != dst_idx_i);
endmodule

// File: rtl/shload_unit.sv
module shload_unit #(
  parameter int XLEN  = 32,
  parameter int HW    = 16,
  parameter int OFS_W = 12,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cond_ok_i,
  input  logic             index_i,
  input  logic             add_i,
  input  logic             wback_i,
  input  logic [IDX_W-1:0] base_idx_i,
  input  logic [IDX_W-1:0] dst_idx_i,
  input  logic [OFS_W-1:0] offs_i,
  input  logic [XLEN-1:0]  base_val_i,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic [XLEN-1:0]  mem_addr_o,
  input  logic             mem_gnt_i,
  input  logic             mem_rvalid_i,
  input  logic [HW-1:0]    mem_rdata_i,
  output logic             done_o,
  output logic             rd_we_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic [XLEN-1:0]  rd_data_o,
  output logic             rb_we_o,
  output logic [IDX_W-1:0] rb_idx_o,
  output logic [XLEN-1:0]  rb_data_o
);
  logic             accept, take;
  logic             index_q, add_q, wback_q;
  logic [IDX_W-1:0] base_idx_q, dst_idx_q;
  logic [OFS_W-1:0] offs_q;
  logic [XLEN-1:0]  base_q;
  logic [XLEN-1:0]  offs_addr, acc_addr;

  shload_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .cond_ok_i(cond_ok_i),
    .gnt_i    (mem_gnt_i),
    .rvalid_i (mem_rvalid_i),
    .accept_o (accept),
    .take_o   (take),
    .req_o    (mem_req_o),
    .busy_o   (busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      index_q    <= 1'b0;
      add_q      <= 1'b0;
      wback_q    <= 1'b0;
      base_idx_q <= '0;
      dst_idx_q  <= '0;
      offs_q     <= '0;
      base_q     <= '0;
    end else if (accept) begin
      index_q    <= index_i;
      add_q      <= add_i;
      wback_q    <= wback_i;
      base_idx_q <= base_idx_i;
      dst_idx_q  <= dst_idx_i;
      offs_q     <= offs_i;
      base_q     <= base_val_i;
    end
  end

  shload_agu #(.XLEN(XLEN), .OFS_W(OFS_W)) u_agu (
    .base_i     (base_q),
    .offs_i     (offs_q),
    .add_i      (add_q),
    .index_i    (index_q),
    .offs_addr_o(offs_addr),
    .acc_addr_o (acc_addr)
  );

  assign mem_addr_o = acc_addr;

  shload_result #(.XLEN(XLEN), .HW(HW), .IDX_W(IDX_W)) u_res (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (take),
    .rdata_i   (mem_rdata_i),
    .wback_i   (wback_q),
    .base_idx_i(base_idx_q),
    .dst_idx_i (dst_idx_q),
    .done_o    (done_o),
    .rd_we_o   (rd_we_o),
    .rd_data_o (rd_data_o),
    .rb_we_o   (rb_we_o)
  );

  assign rd_idx_o  = dst_idx_q;
  assign rb_idx_o  = base_idx_q;
  assign rb_data_o = offs_addr;
endmodule

// File: rtl/shload_chk.sv
module shload_chk #(
  parameter int XLEN  = 32,
  parameter int HW    = 16,
  parameter int IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             cond_ok_i,
  input logic             busy_o,
  input logic             mem_req_o,
  input logic [XLEN-1:0]  mem_addr_o,
  input logic             mem_gnt_i,
  input logic             mem_rvalid_i,
  input logic [HW-1:0]    mem_rdata_i,
  input logic             done_o,
  input logic             rd_we_o,
  input logic [IDX_W-1:0] rd_idx_o,
  input logic [XLEN-1:0]  rd_data_o,
  input logic             rb_we_o,
  input logic [IDX_W-1:0] rb_idx_o
);
  a_r3_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o));

  a_r4_no_req_on_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i && !cond_ok_i |=> !mem_req_o && !busy_o);

  a_r5_low_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |-> rd_data_o[HW-1:0] == $past(mem_rdata_i));

  a_r6_we_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o == done_o);

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_done_after_rvalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_rvalid_i));

  a_r7_rb_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_we_o |-> done_o);

  a_r8_no_collision: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_we_o |-> rb_idx_o != rd_idx_o);
endmodule

bind shload_unit shload_chk #(.XLEN(XLEN), .HW(HW), .IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .cond_ok_i   (cond_ok_i),
  .busy_o      (busy_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_gnt_i   (mem_gnt_i),
  .mem_rvalid_i(mem_rvalid_i),
  .mem_rdata_i (mem_rdata_i),
  .done_o      (done_o),
  .rd_we_o     (rd_we_o),
  .rd_idx_o    (rd_idx_o),
  .rd_data_o   (rd_data_o),
  .rb_we_o     (rb_we_o),
  .rb_idx_o    (rb_idx_o)
);

// File: tb/tb_shload_unit.sv
module tb_shload_unit;
  localparam int ClkPeriod = 10;
  localparam int XLEN = 32, HW = 16, OFS_W = 12, IDX_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, cond_ok = 0, index = 0, add = 0, wback = 0;
  logic [IDX_W-1:0] bidx = '0, didx = '0;
  logic [OFS_W-1:0] offs = '0;
  logic [XLEN-1:0] base = '0;
  logic gnt = 0, rvalid = 0;
  logic [HW-1:0] rdata = '0;
  logic busy, req, done, rd_we, rb_we;
  logic [XLEN-1:0] addr, rd_data, rb_data;
  logic [IDX_W-1:0] rd_idx, rb_idx;

  int checks = 0, errors = 0;

  always #(ClkPeriod/2) clk = ~clk;

  shload_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cond_ok_i(cond_ok),
    .index_i(index), .add_i(add), .wback_i(wback), .base_idx_i(bidx),
    .dst_idx_i(didx), .offs_i(offs), .base_val_i(base), .busy_o(busy),
    .mem_req_o(req), .mem_addr_o(addr), .mem_gnt_i(gnt), .mem_rvalid_i(rvalid),
    .mem_rdata_i(rdata), .done_o(done), .rd_we_o(rd_we), .rd_idx_o(rd_idx),
    .rd_data_o(rd_data), .rb_we_o(rb_we), .rb_idx_o(rb_idx), .rb_data_o(rb_data)
  );

  // behavioural reference model
  int m_phase = 0;
  bit m_done = 0, m_idx = 0, m_add = 0, m_wb = 0;
  int unsigned m_base = 0, m_offs = 0, m_bi = 0, m_di = 0, m_half = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_phase == 0) begin
        if (start && cond_ok) begin
          m_idx = index; m_add = add; m_wb = wback; m_bi = bidx; m_di = didx;
          m_offs = offs; m_base = base; m_phase = 1;
        end
      end else if (m_phase == 1) begin
        if (gnt) m_phase = 2;
      end else if (rvalid) begin
        m_half = rdata; m_done = 1; m_phase = 0;
      end
    end
  end

  function automatic int unsigned ofs_addr();
    return m_add ? m_base + m_offs : m_base - m_offs;
  endfunction

  task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison away from the edge
  always @(negedge clk) if (rst_n) begin
    int unsigned exp_rd;
    exp_rd = m_half[15] ? (m_half | 32'hFFFF0000) : m_half;
    chk("R9 busy", busy, m_phase != 0);
    chk("R3 req", req, m_phase == 1);
    if (m_phase == 1) chk("R1/R2 addr", addr, m_idx ? ofs_addr() : m_base);
    chk("R6 done", done, m_done);
    chk("R6 rd_we", rd_we, m_done);
    if (m_done) begin
      chk("R6 rd_idx", rd_idx, m_di);
      chk("R5 rd_data", rd_data, exp_rd);
    end
    chk("R7/R8 rb_we", rb_we, m_done && m_wb && (m_bi != m_di));
    if (m_done && m_wb && m_bi != m_di) chk("R7 rb_data", rb_data, ofs_addr());
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // run one load; returns cycles from rvalid edge to done
  task automatic run(input bit ix, input bit ad, input bit wb, input int bi, input int di,
                     input int of, input int unsigned bv, input int gd, input int rd,
                     input logic [HW-1:0] val, output int lat);
    @(negedge clk);
    start = 1; cond_ok = 1; index = ix; add = ad; wback = wb;
    bidx = bi[IDX_W-1:0]; didx = di[IDX_W-1:0]; offs = of[OFS_W-1:0]; base = bv;
    @(negedge clk);
    start = 0; base = ~bv;
    cyc(gd);
    gnt = 1; @(negedge clk); gnt = 0;
    cyc(rd);
    rvalid = 1; rdata = val; @(negedge clk); rvalid = 0; rdata = ~val;
    lat = done ? 1 : 0;
    cyc(2);
  endtask

  initial begin
    #(ClkPeriod * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat_a, lat_b;
    cyc(2); rst_n = 1; cyc(1);
    // R11 reset state
    chk("R11 req", req, 0); chk("R11 done", done, 0); chk("R11 busy", busy, 0);
    chk("R11 rd_we", rd_we, 0); chk("R11 rb_we", rb_we, 0);

    // R1/R2 all mode combinations, wrap at both ends
    run(1, 1, 0, 1, 2, 12'h010, 32'h0000_1000, 0, 0, 16'h1234, lat_a);
    run(1, 0, 1, 3, 4, 12'h004, 32'h0000_0002, 2, 1, 16'h8000, lat_a);
    run(0, 1, 1, 5, 6, 12'hFFF, 32'hFFFF_FF00, 1, 3, 16'h7FFF, lat_a);
    run(0, 0, 1, 7, 8, 12'h0FF, 32'h0000_0010, 0, 2, 16'hFFFF, lat_a);
    run(1, 1, 1, 9, 9, 12'h002, 32'hFFFF_FFFF, 3, 0, 16'h8001, lat_a); // R8 collision
    chk("R1 wrap rb_data", rb_data, 32'h0000_0001);

    // R8 explicit: collision drops base write
    @(negedge clk);
    start = 1; cond_ok = 1; index = 0; add = 1; wback = 1; bidx = 4'd3; didx = 4'd3;
    offs = 12'h8; base = 32'h100;
    @(negedge clk); start = 0; gnt = 1; @(negedge clk); gnt = 0;
    rvalid = 1; rdata = 16'h0042; @(negedge clk); rvalid = 0;
    chk("R8 rd_we", rd_we, 1); chk("R8 rb_we", rb_we, 0);
    cyc(2);

    // R4 condition failed
    @(negedge clk); start = 1; cond_ok = 0; @(negedge clk); start = 0;
    chk("R4 busy", busy, 0); chk("R4 req", req, 0);
    cyc(3); chk("R4 done", done, 0); chk("R4 rd_we", rd_we, 0);

    // R9 start while busy ignored
    @(negedge clk);
    start = 1; cond_ok = 1; index = 1; add = 1; wback = 0; bidx = 1; didx = 2;
    offs = 12'h20; base = 32'h4000;
    @(negedge clk); start = 1; base = 32'h9999_0000; offs = 12'h1;
    @(negedge clk); start = 0;
    chk("R9 addr", addr, 32'h4020);
    gnt = 1; @(negedge clk); gnt = 0; start = 1; @(negedge clk); start = 0;
    rvalid = 1; rdata = 16'hC000; @(negedge clk); rvalid = 0;
    chk("R9 result", rd_data, 32'hFFFF_C000);
    chk("R7 no wb", rb_we, 0);
    cyc(2);

    // R10 latency independent of data
    run(1, 1, 0, 1, 2, 0, 32'h200, 1, 1, 16'h8000, lat_a);
    run(1, 1, 0, 1, 2, 0, 32'h200, 1, 1, 16'h0001, lat_b);
    chk("R10 latency neg", lat_a, 1);
    chk("R10 latency pos", lat_b, 1);

    cyc(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule